// File: doc/BRIEF.md
# Two-Set Receive DMA Channel

This block is the receive side of a DMA channel that runs from two alternating register sets instead of a descriptor ring. Each set holds a base address, a count of entries still free, and a command word. Software loads and starts one set while the other one is filling. Each arriving frame takes one fixed-size record slot, and the block issues a single write request carrying that slot's address. The data path that carries the record itself is outside this block.

When the set in use writes its last free entry, it stops by itself, the completion status goes up, and the channel moves to the other set. If the set in use is idle but the other set is ready, the next frame goes to the other set, which then becomes the one in use. If neither set is ready, the frame is lost and a drop counter goes up. A small register map carries channel commands, status, the drop count and both register sets. An interrupt line follows the error and completion status bits.

Top module: `pp_dma_rx`

## Requirements
- R1: After synchronous reset, the status word reads 0, the drop counter reads 0, every set field reads 0, and `irq` and `wr_req` are low.
- R2: Set 0's base, count and command registers sit at offsets 0x20, 0x24 and 0x28. Set 1 uses the same layout 0x10 higher, at 0x30, 0x34 and 0x38. A base write reads back unchanged.
- R3: A frame accepted in cycle k gives a one-cycle `wr_req` in cycle k+1. Its `wr_addr` is base + n×ENTRY_BYTES, where n counts the entries taken from that set since its base or count was last written. ENTRY_BYTES defaults to 1536.
- R4: The count register of a set reads back the number of free entries. Each entry the set takes lowers it by one.
- R5: The set command codes are:
  - 0x9800 starts the set.
  - 0x1100 halts it.
  - 0x0100 halts it and rewinds its next address to its base, leaving the count unchanged.
  - Any other value is ignored: the set stays idle and its command word is not updated.
- R6: When a set takes its last free entry, it stops, status bit 8 (done) sets, and status bit 0 (set in use) changes to the other set.
- R7: If the set in use is not ready (halted, or count zero) and the other set is running with a nonzero count, the frame is written to the other set, and status bit 0 switches to it.
- R8: A frame arriving while the channel is enabled and neither set is ready produces no write request. The drop counter at offset 0x04 goes up by one.
- R9: The channel control codes, written to offset 0x00, are:
  - 0x0400 enables the channel (status bit 10).
  - 0x1000 disables it.
  - 0x8800 resets it: it disables the channel, clears the error and done bits, halts both sets and selects set 0.
  
  While the channel is disabled, frames are ignored and the drop counter does not change.
- R10: Starting a set whose count is zero sets status bit 13 (error). Only a channel reset clears it.
- R11: `irq` is high exactly while the error or done bit is set. A halt command to either set clears the done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| rx_valid | input | 1 | One-cycle pulse per arriving frame |
| wr_req | output | 1 | Record write request |
| wr_addr | output | 32 | Record start address |
| irq | output | 1 | Interrupt: error or done pending |

## Verification
The bench drives a chain through to exhaustion and checks three things there: that the done bit and the switch of set in use happen on the last entry and not one entry early, and that the next frame is dropped rather than written past the end. It checks that a frame reaches the other set when the set in use is idle; a design that only ever used the set in use would count a false drop. It checks that a command code the block does not know leaves the set idle, and that a rewind restores the base address but not the count; a design that decoded commands loosely would start writing. It checks that a start with zero count raises an error that survives a halt, and that a disabled channel neither writes nor counts drops.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int REG_W = 32;
    localparam int CMD_W = 16;

    localparam int ST_ACT_BIT  = 0;
    localparam int ST_DONE_BIT = 8;
    localparam int ST_EN_BIT   = 10;
    localparam int ST_ERR_BIT  = 13;

    typedef enum logic [CMD_W-1:0] {
        SET_START = 16'h9800,
        SET_HALT  = 16'h1100,
        SET_PREP  = 16'h0100
    } set_cmd_e;

    typedef enum logic [CMD_W-1:0] {
        CH_RESET   = 16'h8800,
        CH_ENABLE  = 16'h0400,
        CH_DISABLE = 16'h1000
    } ch_cmd_e;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] ptr;
        logic             ready;
        logic             last;
    } set_view_t;

    function automatic int round_up(input int bytes, input int align);
        return ((bytes + align - 1) / align) * align;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic err, input logic en,
                                                     input logic done, input logic act);
        logic [REG_W-1:0] w;
        w = '0;
        w[ST_ERR_BIT]  = err;
        w[ST_EN_BIT]   = en;
        w[ST_DONE_BIT] = done;
        w[ST_ACT_BIT]  = act;
        return w;
    endfunction

endpackage

// File: rtl/pp_dma_regset.sv
module pp_dma_regset
    import pp_dma_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ENTRY_BYTES = 1536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_rst,
    input  logic             wr_base,
    input  logic             wr_len,
    input  logic             wr_cmd,
    input  logic [REG_W-1:0] wdata,
    input  logic             consume,
    output set_view_t        view,
    output logic [CNT_W-1:0] remaining,
    output logic [CMD_W-1:0] cmd_word,
    output logic             start_err,
    output logic             halt_seen
);
    localparam logic [REG_W-1:0] STEP = REG_W'(ENTRY_BYTES);

    logic [REG_W-1:0] base_q, ptr_q;
    logic [CNT_W-1:0] rem_q;
    logic [CMD_W-1:0] cmd_q;
    logic             run_q;
    logic [CMD_W-1:0] code;
    logic             known;

    assign code      = wdata[CMD_W-1:0];
    assign known     = (code == SET_START) || (code == SET_HALT) || (code == SET_PREP);
    assign start_err = wr_cmd && (code == SET_START) && (rem_q == '0);
    assign halt_seen = wr_cmd && (code == SET_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ptr_q  <= '0;
            rem_q  <= '0;
            cmd_q  <= '0;
            run_q  <= 1'b0;
        end else begin
            if (consume) begin
                ptr_q <= ptr_q + STEP;
                rem_q <= rem_q - 1'b1;
                if (rem_q == CNT_W'(1))
                    run_q <= 1'b0;
            end
            if (wr_base) begin
                base_q <= wdata;
                ptr_q  <= wdata;
            end
            if (wr_len) begin
                rem_q <= wdata[CNT_W-1:0];
                ptr_q <= base_q;
            end
            if (wr_cmd && known) begin
                cmd_q <= code;
                if (code == SET_START)
                    run_q <= (rem_q != '0);
                else
                    run_q <= 1'b0;
                if (code == SET_PREP)
                    ptr_q <= base_q;
            end
            if (chan_rst)
                run_q <= 1'b0;
        end
    end

    assign view.base  = base_q;
    assign view.ptr   = ptr_q;
    assign view.ready = run_q && (rem_q != '0);
    assign view.last  = (rem_q == CNT_W'(1));
    assign remaining  = rem_q;
    assign cmd_word   = cmd_q;

endmodule

// File: rtl/pp_dma_pick.sv
module pp_dma_pick (
    input  logic       rx_valid,
    input  logic       en,
    input  logic       active,
    input  logic [1:0] ready,
    input  logic [1:0] last,
    output logic       take,
    output logic       drop,
    output logic       sel,
    output logic       fin,
    output logic       next_active
);
    logic any_ready;

    always_comb begin
        any_ready   = ready[active] || ready[!active];
        sel         = ready[active] ? active : !active;
        take        = rx_valid && en && any_ready;
        drop        = rx_valid && en && !any_ready;
        fin         = take && last[sel];
        next_active = take ? (fin ? !sel : sel) : active;
    end

endmodule

// File: rtl/pp_dma_rx.sv
module pp_dma_rx
    import pp_dma_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int OVF_W       = 8,
    parameter int ENTRY_BYTES = pp_dma_pkg::round_up(1522, 16)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_valid,
    output logic        wr_req,
    output logic [31:0] wr_addr,
    output logic        irq
);
    localparam int NSETS = 2;

    set_view_t        view   [NSETS];
    logic [CNT_W-1:0] rem    [NSETS];
    logic [CMD_W-1:0] cmdw   [NSETS];
    logic [NSETS-1:0] ready, last, serr, shalt, consume;

    logic             en_q, err_q, done_q, active_q;
    logic [OVF_W-1:0] ovf_q;
    logic             ctl_wr, chan_rst;
    logic             take, drop, sel, fin, next_active;

    assign ctl_wr   = reg_we && (reg_addr == 6'h00);
    assign chan_rst = ctl_wr && (reg_wdata[CMD_W-1:0] == CH_RESET);

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        logic hit;
        assign hit        = reg_we && reg_addr[5] && (reg_addr[4] == 1'(s));
        assign consume[s] = take && (sel == 1'(s));
        assign ready[s]   = view[s].ready;
        assign last[s]    = view[s].last;

        pp_dma_regset #(.CNT_W(CNT_W), .ENTRY_BYTES(ENTRY_BYTES)) u_set (
            .clk       (clk),
            .rst       (rst),
            .chan_rst  (chan_rst),
            .wr_base   (hit && (reg_addr[3:0] == 4'h0)),
            .wr_len    (hit && (reg_addr[3:0] == 4'h4)),
            .wr_cmd    (hit && (reg_addr[3:0] == 4'h8)),
            .wdata     (reg_wdata),
            .consume   (consume[s]),
            .view      (view[s]),
            .remaining (rem[s]),
            .cmd_word  (cmdw[s]),
            .start_err (serr[s]),
            .halt_seen (shalt[s])
        );
    end

    pp_dma_pick u_pick (
        .rx_valid    (rx_valid),
        .en          (en_q),
        .active      (active_q),
        .ready       (ready),
        .last        (last),
        .take        (take),
        .drop        (drop),
        .sel         (sel),
        .fin         (fin),
        .next_active (next_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
            active_q <= 1'b0;
            ovf_q    <= '0;
            wr_req   <= 1'b0;
            wr_addr  <= '0;
        end else begin
            wr_req   <= take;
            if (take)
                wr_addr <= view[sel].ptr;
            active_q <= next_active;
            if (drop && (ovf_q != '1))
                ovf_q <= ovf_q + 1'b1;
            if (|shalt)
                done_q <= 1'b0;
            if (fin)
                done_q <= 1'b1;
            if (|serr)
                err_q <= 1'b1;
            if (ctl_wr) begin
                if (reg_wdata[CMD_W-1:0] == CH_ENABLE)
                    en_q <= 1'b1;
                if (reg_wdata[CMD_W-1:0] == CH_DISABLE)
                    en_q <= 1'b0;
            end
            if (chan_rst) begin
                en_q     <= 1'b0;
                err_q    <= 1'b0;
                done_q   <= 1'b0;
                active_q <= 1'b0;
            end
        end
    end

    assign irq = err_q || done_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[5]) begin
            case (reg_addr[3:0])
                4'h0:    reg_rdata = view[reg_addr[4]].base;
                4'h4:    reg_rdata = 32'(rem[reg_addr[4]]);
                4'h8:    reg_rdata = 32'(cmdw[reg_addr[4]]);
                default: reg_rdata = '0;
            endcase
        end else if (reg_addr == 6'h00) begin
            reg_rdata = status_word(err_q, en_q, done_q, active_q);
        end else if (reg_addr == 6'h04) begin
            reg_rdata = 32'(ovf_q);
        end
    end

endmodule

// File: rtl/pp_dma_rx_chk.sv
module pp_dma_rx_chk #(
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             wr_req,
    input logic             irq,
    input logic             en_q,
    input logic             err_q,
    input logic [OVF_W-1:0] ovf_q,
    input logic             reg_we,
    input logic [5:0]       reg_addr,
    input logic [31:0]      reg_wdata
);
    // R3
    wr_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> $past(rx_valid));

    // R9
    wr_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> $past(en_q));

    // R8
    drop_count_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q != $past(ovf_q)) |-> ($past(rx_valid) && !wr_req));

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_q) |-> $past(reg_we && (reg_addr == 6'h00) && (reg_wdata[15:0] == 16'h8800)));

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(rx_valid) || $past(reg_we)));

endmodule

bind pp_dma_rx pp_dma_rx_chk #(.OVF_W(OVF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .wr_req    (wr_req),
    .irq       (irq),
    .en_q      (en_q),
    .err_q     (err_q),
    .ovf_q     (ovf_q),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/pp_dma_rx_bench.sv
module pp_dma_rx_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];

    pp_dma_rx u_pp_dma_rx (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .wr_req(wr_req), .wr_addr(wr_addr), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic frame(input bit hit, input logic [31:0] exp_addr);
        @(negedge clk);
        if (hit) exp_q.push_back(exp_addr);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
    endtask

    // monitor: compares every write request with the scoreboard (R3)
    always @(negedge clk) begin
        if (!rst && wr_req) begin
            if (exp_q.size() == 0)
                check(1'b0, "R3 unexpected write", wr_addr, 32'hFFFF_FFFF);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(wr_addr == e, "R3 write address", wr_addr, e);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_chk(6'h00, 32'h0, "R1 status");
        rd_chk(6'h04, 32'h0, "R1 drops");
        rd_chk(6'h24, 32'h0, "R1 count");
        check(irq == 1'b0 && wr_req == 1'b0, "R1 irq/wr_req", {30'b0, irq, wr_req}, 32'h0);

        // R2 layout
        wr(6'h20, 32'h0000_1000); wr(6'h24, 3);
        wr(6'h30, 32'h0000_8000); wr(6'h34, 2);
        rd_chk(6'h30, 32'h0000_8000, "R2 set1 base");
        rd_chk(6'h20, 32'h0000_1000, "R2 set0 base");
        rd_chk(6'h34, 32'h2, "R2 set1 count");

        // R9 enable
        wr(6'h00, 32'h0400);
        rd_chk(6'h00, 32'h0400, "R9 enable");

        // R5 unknown code ignored, R8 drop
        wr(6'h28, 32'h1234);
        rd_chk(6'h28, 32'h0, "R5 unknown code");
        frame(0, 0);
        rd_chk(6'h04, 32'h1, "R8 drop count");

        // R3 / R4 chain on set 0
        wr(6'h28, 32'h9800);
        frame(1, 32'h1000);
        rd_chk(6'h24, 32'h2, "R4 count after one");
        frame(1, 32'h1600);
        rd_chk(6'h00, 32'h0400, "R6 not done early");
        frame(1, 32'h1C00);
        // R6 done, switch; R11 irq
        rd_chk(6'h00, 32'h0501, "R6 done+switch");
        check(irq == 1'b1, "R11 irq on done", {31'b0, irq}, 32'h1);
        rd_chk(6'h24, 32'h0, "R4 count zero");
        frame(0, 0);
        rd_chk(6'h04, 32'h2, "R8 drop after exhaust");

        // R11 halt clears done
        wr(6'h28, 32'h1100);
        rd_chk(6'h00, 32'h0401, "R11 halt clears done");
        check(irq == 1'b0, "R11 irq low", {31'b0, irq}, 32'h0);

        // set 1 chain
        wr(6'h38, 32'h9800);
        frame(1, 32'h8000);
        frame(1, 32'h8600);
        rd_chk(6'h00, 32'h0500, "R6 set1 done");
        wr(6'h38, 32'h1100);

        // R7 fallback to the other set
        wr(6'h34, 2); wr(6'h38, 32'h9800);
        frame(1, 32'h8000);
        rd_chk(6'h00, 32'h0401, "R7 fallback active");
        wr(6'h38, 32'h1100);

        // R5 prepare rewinds pointer, keeps count
        wr(6'h24, 3); wr(6'h28, 32'h9800);
        frame(1, 32'h1000);
        rd_chk(6'h00, 32'h0400, "R7 back to set0");
        wr(6'h28, 32'h0100);
        rd_chk(6'h28, 32'h0100, "R5 prepare word");
        frame(0, 0);
        rd_chk(6'h04, 32'h3, "R5 prepare halts");
        wr(6'h28, 32'h9800);
        frame(1, 32'h1000);
        rd_chk(6'h24, 32'h1, "R5 count kept");

        // R10 start with zero count
        wr(6'h34, 0); wr(6'h38, 32'h9800);
        rd_chk(6'h00, 32'h2400, "R10 error set");
        wr(6'h38, 32'h1100);
        rd_chk(6'h00, 32'h2400, "R10 survives halt");
        check(irq == 1'b1, "R11 irq on error", {31'b0, irq}, 32'h1);
        wr(6'h00, 32'h8800);
        rd_chk(6'h00, 32'h0, "R9 reset clears");
        check(irq == 1'b0, "R10 irq cleared", {31'b0, irq}, 32'h0);

        // R9 disabled channel ignores frames
        wr(6'h24, 1); wr(6'h28, 32'h9800);
        frame(0, 0);
        rd_chk(6'h04, 32'h3, "R9 disabled no drop");
        wr(6'h00, 32'h0400); wr(6'h00, 32'h1000);
        rd_chk(6'h00, 32'h0, "R9 disable");
        frame(0, 0);
        rd_chk(6'h04, 32'h3, "R9 disabled no drop 2");
        wr(6'h00, 32'h0400);
        frame(1, 32'h1000);
        rd_chk(6'h00, 32'h0501, "R6 single entry");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 missing writes", exp_q.size(), 0);
        finish_run();
    end

endmodule